// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Command and Data Sequencer

This block sits between a host and a synchronous SRAM that has separate write-data and read-data buses and always moves two words per command. Each accepted host request becomes one command on the memory's control pins: an active-low load strobe, a read/write level and a pair address. The memory samples these on the rising edge of its K clock. Write data is handed to an external double-data-rate output register as a rising-phase word and a falling-phase word. Read data comes back from an external double-data-rate input register as a falling-phase word followed by a rising-phase word. The block joins the two read words into one pair and returns it to the host with the request's tag.

Every control and data output is registered. The host sees a ready signal that stays high whenever reset is low, so one request can be accepted every cycle, with reads and writes mixed freely. A cycle with no accepted request becomes a no-operation. Write data trails its command by one cycle. Read data trails its command by several cycles. Both latencies are tracked at the same time by independent shift pipelines.

A static configuration input states how the read words are timed. When it is low, the words are assumed to be timed by K. When it is high, the words arrive on the echo output clocks, and the input path adds one retiming stage, so every read word reaches the capture ports one cycle later.

Top module: `burst2_sram_ctrl`

## Requirements
In the requirements below, "edge a" is the rising clock edge at which `req_valid` and `req_ready` are both high, and "cycle a+n" is the clock period that follows edge a+n.
- R1: While `rst` is high, from the first clock edge on, `sram_ld_n` is 1, `wd_oe` is 0, `rd_valid` is 0 and `req_ready` is 0. A request presented in the same cycle as reset produces no command and no write data.
- R2: A request accepted at edge a drives `sram_ld_n`=0 in cycle a, with `sram_addr` equal to `req_addr`. In that cycle `sram_rw` is 1 for a read (`req_write`=0) and 0 for a write (`req_write`=1).
- R3: In a cycle that follows an edge with no accepted request, `sram_ld_n` is 1. This holds whatever level `req_write` has, and `req_write` has no effect on the memory pins while `req_valid` is low.
- R4: For a write accepted at edge a, `wd_oe` is 1 in cycle a+1, with `wd_rise`=`req_wdata0` (word at pair offset 0) and `wd_fall`=`req_wdata1` (word at pair offset 1). In every other cycle `wd_oe` is 0.
- R5: With `cfg_echo`=0, a read accepted at edge a takes word 0 from `cap_fall` at edge a+3 and word 1 from `cap_rise` at edge a+4. It then shows `rd_valid`=1 in cycle a+4, together with those words on `rd_data0` and `rd_data1` and its own `req_tag` on `rd_tag`.
- R6: With `cfg_echo`=1, the same read takes `cap_fall` at edge a+4 and `cap_rise` at edge a+5, and shows `rd_valid`=1 with its data and tag in cycle a+5.
- R7: After reset, `req_ready` is 1 in every cycle. Requests on consecutive cycles, mixing reads and writes in any order, are all accepted, and no idle cycle is inserted between their commands.
- R8: `rd_valid` is 1 only in the cycles named by R5 or R6. A write never causes `rd_valid`, and back-to-back reads return in order, each pair carrying its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | K-domain clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_echo | input | 1 | 1: read words timed by echo clocks (one extra cycle); 0: timed by K. Static while reads are in flight |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Host request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Pair address of the two-word burst |
| req_tag | input | TAG_W | Tag returned with read data |
| req_wdata0 | input | DATA_W | Write word for pair offset 0 |
| req_wdata1 | input | DATA_W | Write word for pair offset 1 |
| sram_ld_n | output | 1 | Active-low load strobe to the memory |
| sram_rw | output | 1 | Read/write level: 1 read, 0 write |
| sram_addr | output | ADDR_W | Address to the memory |
| wd_rise | output | DATA_W | Rising-phase write word to the DDR output register |
| wd_fall | output | DATA_W | Falling-phase write word to the DDR output register |
| wd_oe | output | 1 | Write data output enable |
| cap_fall | input | DATA_W | Falling-phase word from the DDR input register |
| cap_rise | input | DATA_W | Rising-phase word from the DDR input register |
| rd_valid | output | 1 | One-cycle pulse: a read pair is returned |
| rd_tag | output | TAG_W | Tag of the returned read |
| rd_data0 | output | DATA_W | Returned word at pair offset 0 |
| rd_data1 | output | DATA_W | Returned word at pair offset 1 |

## Verification
The bench numbers each rising edge. When a request is accepted at edge a, the bench records what each output should show: the command in cycle a, the write pair in cycle a+1, and the read pair in cycle a+4, or a+5 with echo timing. A behavioural memory serves the capture ports with the same half-cycle offsets, and the expected read data come from a shadow copy that the bench updates at acceptance time. At every falling edge, a monitor compares all outputs against the record for that edge number. This makes a result that arrives one cycle early or late show up as a mismatch, and a cycle with no record must show idle outputs.

// File: rtl/burst2_pkg.sv
`timescale 1ns/1ps
package burst2_pkg;
  // read/write pin level
  typedef enum logic {RW_WRITE = 1'b0, RW_READ = 1'b1} rw_lvl_e;

  // tracker stage whose valid marks the edge that captures word 0 under K timing
  localparam int B2_CAP_K0     = 2;
  // additional cycles added by the echo-clock retiming stage
  localparam int B2_ECHO_SLIP  = 1;
  // stages needed: word-0 tap, word-1 tap, plus the echo slip
  localparam int B2_TRACK_DEPTH = B2_CAP_K0 + 2 + B2_ECHO_SLIP;
endpackage

// File: rtl/b2_cmd_issue.sv
`timescale 1ns/1ps
module b2_cmd_issue
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata0,
  input  logic [DATA_W-1:0] req_wdata1,
  output logic              req_ready,
  output logic              rd_push,
  output logic              sram_ld_n,
  output logic              sram_rw,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] wd_rise,
  output logic [DATA_W-1:0] wd_fall,
  output logic              wd_oe
);
  logic              fire;
  logic              wr_pend;
  logic [DATA_W-1:0] pend0, pend1;
  rw_lvl_e           rw_nxt;

  always_comb begin
    fire    = req_valid && req_ready;
    rd_push = fire && !req_write;
    rw_nxt  = (fire && req_write) ? RW_WRITE : RW_READ;
  end

  // command stage: driven in the cycle after acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      sram_ld_n <= 1'b1;
      sram_rw   <= RW_READ;
      sram_addr <= '0;
      wr_pend   <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      sram_ld_n <= !fire;
      sram_rw   <= rw_nxt;
      wr_pend   <= fire && req_write;
      if (fire) sram_addr <= req_addr;
    end
  end

  // write data holding registers (no reset needed)
  always_ff @(posedge clk) begin
    if (fire && req_write) begin
      pend0 <= req_wdata0;
      pend1 <= req_wdata1;
    end
  end

  // write data stage: one cycle behind the command
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_oe <= 1'b0;
    end else begin
      wd_oe <= wr_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_pend) begin
      wd_rise <= pend0;
      wd_fall <= pend1;
    end
  end
endmodule

// File: rtl/b2_rd_track.sv
`timescale 1ns/1ps
module b2_rd_track #(
  parameter int TAG_W     = 4,
  parameter int DEPTH     = 5,
  parameter int FIRST_TAP = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                push,
  input  logic [TAG_W-1:0]                    push_tag,
  output logic [DEPTH-1:FIRST_TAP]            tail_v,
  output logic [(DEPTH-FIRST_TAP-1)*TAG_W-1:0] tail_tag
);
  logic [DEPTH-1:0] v_q;
  logic [TAG_W-1:0] tag_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q[0] <= 1'b0;
        else     v_q[0] <= push;
        tag_q[0] <= push_tag;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= v_q[g-1];
        tag_q[g] <= tag_q[g-1];
      end
    end
    if (g >= FIRST_TAP) begin : g_vtap
      assign tail_v[g] = v_q[g];
    end
    if (g > FIRST_TAP) begin : g_ttap
      assign tail_tag[(g-FIRST_TAP-1)*TAG_W +: TAG_W] = tag_q[g];
    end
  end
endmodule

// File: rtl/b2_rd_capture.sv
`timescale 1ns/1ps
module b2_rd_capture #(
  parameter int DATA_W = 18,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_echo,
  input  logic              k_w0,
  input  logic              k_w1,
  input  logic              e_w1,
  input  logic [TAG_W-1:0]  k_tag,
  input  logic [TAG_W-1:0]  e_tag,
  input  logic [DATA_W-1:0] cap_fall,
  input  logic [DATA_W-1:0] cap_rise,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data0,
  output logic [DATA_W-1:0] rd_data1
);
  logic              take0, take1;
  logic [TAG_W-1:0]  tag1;
  logic [DATA_W-1:0] hold0;

  // echo timing shifts both taps one stage later
  always_comb begin
    take0 = cfg_echo ? k_w1  : k_w0;
    take1 = cfg_echo ? e_w1  : k_w1;
    tag1  = cfg_echo ? e_tag : k_tag;
  end

  always_ff @(posedge clk) begin
    if (take0) hold0 <= cap_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= take1;
  end

  always_ff @(posedge clk) begin
    if (take1) begin
      rd_data0 <= hold0;
      rd_data1 <= cap_rise;
      rd_tag   <= tag1;
    end
  end
endmodule

// File: rtl/burst2_sram_ctrl.sv
`timescale 1ns/1ps
module burst2_sram_ctrl
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_echo,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata0,
  input  logic [DATA_W-1:0] req_wdata1,
  output logic              sram_ld_n,
  output logic              sram_rw,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] wd_rise,
  output logic [DATA_W-1:0] wd_fall,
  output logic              wd_oe,
  input  logic [DATA_W-1:0] cap_fall,
  input  logic [DATA_W-1:0] cap_rise,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data0,
  output logic [DATA_W-1:0] rd_data1
);
  localparam int TAP0   = B2_CAP_K0;
  localparam int NTAGS  = B2_TRACK_DEPTH - TAP0 - 1;

  logic                         rd_push;
  logic [B2_TRACK_DEPTH-1:TAP0] tail_v;
  logic [NTAGS*TAG_W-1:0]       tail_tag;

  b2_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
    .req_ready(req_ready), .rd_push(rd_push),
    .sram_ld_n(sram_ld_n), .sram_rw(sram_rw), .sram_addr(sram_addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wd_oe(wd_oe)
  );

  b2_rd_track #(.TAG_W(TAG_W), .DEPTH(B2_TRACK_DEPTH), .FIRST_TAP(TAP0)) u_track (
    .clk(clk), .rst(rst),
    .push(rd_push), .push_tag(req_tag),
    .tail_v(tail_v), .tail_tag(tail_tag)
  );

  b2_rd_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap (
    .clk(clk), .rst(rst), .cfg_echo(cfg_echo),
    .k_w0(tail_v[TAP0]),
    .k_w1(tail_v[TAP0+1]),
    .e_w1(tail_v[TAP0+1+B2_ECHO_SLIP]),
    .k_tag(tail_tag[0 +: TAG_W]),
    .e_tag(tail_tag[B2_ECHO_SLIP*TAG_W +: TAG_W]),
    .cap_fall(cap_fall), .cap_rise(cap_rise),
    .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_data0(rd_data0), .rd_data1(rd_data1)
  );
endmodule

// File: rtl/burst2_sram_ctrl_chk.sv
`timescale 1ns/1ps
module burst2_sram_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_echo,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              sram_ld_n,
  input logic              sram_rw,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              wd_oe,
  input logic              rd_valid
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (sram_ld_n && !wd_oe && !rd_valid && !req_ready)); // R1
  AST_CMD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> (!sram_ld_n && sram_addr == $past(req_addr) && sram_rw == !$past(req_write))); // R2
  AST_NOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) !(req_valid && req_ready) |=> sram_ld_n); // R3
  AST_WDATA_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) (!sram_ld_n && !sram_rw) |=> wd_oe); // R4
  AST_WDATA_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) wd_oe |-> $past(!sram_ld_n && !sram_rw)); // R4
  AST_RDATA_K_LATENCY: assert property (@(posedge clk) disable iff (rst) (rd_valid && !cfg_echo) |-> $past(!sram_ld_n && sram_rw, 4)); // R5
  AST_RDATA_ECHO_LATENCY: assert property (@(posedge clk) disable iff (rst) (rd_valid && cfg_echo) |-> $past(!sram_ld_n && sram_rw, 5)); // R6
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) !rst |=> req_ready); // R7
endmodule

bind burst2_sram_ctrl burst2_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_echo(cfg_echo),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .sram_ld_n(sram_ld_n), .sram_rw(sram_rw),
  .sram_addr(sram_addr), .wd_oe(wd_oe), .rd_valid(rd_valid)
);

// File: tb/sim_burst2_sram_ctrl.sv
`timescale 1ns/1ps
module sim_burst2_sram_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int NV = 14;
  localparam int VW = 1 + AW + 2*DW + TW + 1;
  localparam int NE = 1024;
  localparam int MW = 2**(AW+1);

  // vector fields: {write, addr, word0, word1, tag, gap_after}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b1, 8'h10, 16'h1111, 16'h2222, 4'h1, 1'b0},
    {1'b1, 8'h11, 16'h3333, 16'h4444, 4'h2, 1'b0},
    {1'b0, 8'h10, 16'h0000, 16'h0000, 4'h3, 1'b0},
    {1'b0, 8'h11, 16'h0000, 16'h0000, 4'h4, 1'b1},
    {1'b1, 8'h20, 16'hAAAA, 16'hBBBB, 4'h5, 1'b0},
    {1'b0, 8'h20, 16'h0000, 16'h0000, 4'h6, 1'b0},
    {1'b1, 8'h20, 16'hCCCC, 16'hDDDD, 4'h7, 1'b0},
    {1'b0, 8'h20, 16'h0000, 16'h0000, 4'h8, 1'b0},
    {1'b0, 8'h33, 16'h0000, 16'h0000, 4'h9, 1'b1},
    {1'b0, 8'h10, 16'h0000, 16'h0000, 4'hA, 1'b0},
    {1'b1, 8'h40, 16'h0F0F, 16'hF0F0, 4'hB, 1'b0},
    {1'b0, 8'h40, 16'h0000, 16'h0000, 4'hC, 1'b0},
    {1'b0, 8'h11, 16'h0000, 16'h0000, 4'hD, 1'b1},
    {1'b0, 8'h40, 16'h0000, 16'h0000, 4'hE, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_echo = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic [DW-1:0] req_wdata0 = '0, req_wdata1 = '0;
  logic          sram_ld_n, sram_rw, wd_oe, rd_valid;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] wd_rise, wd_fall, cap_fall, cap_rise, rd_data0, rd_data1;
  logic [TW-1:0] rd_tag;

  burst2_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) u0 (
    .clk(clk), .rst(rst), .cfg_echo(cfg_echo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_tag(req_tag),
    .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
    .sram_ld_n(sram_ld_n), .sram_rw(sram_rw), .sram_addr(sram_addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wd_oe(wd_oe),
    .cap_fall(cap_fall), .cap_rise(cap_rise),
    .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_data0(rd_data0), .rd_data1(rd_data1)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // behavioural two-word burst memory with the stated latencies
  logic [DW-1:0] mem [MW];
  logic [DW-1:0] shadow [MW];
  logic          wpend = 1'b0, rp1 = 1'b0, rp2 = 1'b0;
  logic [AW-1:0] wpa = '0, rpa1 = '0, rpa2 = '0;
  logic [DW-1:0] kf = '0, kr = '0, kf_d = '0, kr_d = '0;
  logic [DW-1:0] junk;
  assign junk = 16'hE000 ^ DW'(cyc);

  always @(posedge clk) begin
    if (wpend) begin
      mem[{wpa, 1'b0}] <= wd_rise;
      mem[{wpa, 1'b1}] <= wd_fall;
    end
    wpend <= !sram_ld_n && !sram_rw;
    wpa   <= sram_addr;
    rp1   <= !sram_ld_n && sram_rw;
    rpa1  <= sram_addr;
    rp2   <= rp1;
    rpa2  <= rpa1;
    kf    <= rp1 ? mem[{rpa1, 1'b0}] : junk;
    kr    <= rp2 ? mem[{rpa2, 1'b1}] : ~junk;
    kf_d  <= kf;
    kr_d  <= kr;
  end
  assign cap_fall = cfg_echo ? kf_d : kf;
  assign cap_rise = cfg_echo ? kr_d : kr;

  // expectations indexed by edge number
  bit            e_cmd [NE];
  bit            e_rw  [NE];
  logic [AW-1:0] e_addr[NE];
  bit            e_oe  [NE];
  logic [DW-1:0] e_w0  [NE], e_w1 [NE];
  bit            e_rv  [NE];
  logic [TW-1:0] e_tag [NE];
  logic [DW-1:0] e_r0  [NE], e_r1 [NE];

  always @(negedge clk) begin
    if (mon_en && cyc < NE) begin
      chk(req_ready == 1'b1, "R7 ready", 64'(req_ready), 64'd1);
      if (e_cmd[cyc]) begin
        chk(sram_ld_n == 1'b0, "R2 ld_n", 64'(sram_ld_n), 64'd0);
        chk(sram_rw == e_rw[cyc], "R2 rw", 64'(sram_rw), 64'(e_rw[cyc]));
        chk(sram_addr == e_addr[cyc], "R2 addr", 64'(sram_addr), 64'(e_addr[cyc]));
      end else begin
        chk(sram_ld_n == 1'b1, "R3 nop", 64'(sram_ld_n), 64'd1);
      end
      chk(wd_oe == e_oe[cyc], "R4 wd_oe", 64'(wd_oe), 64'(e_oe[cyc]));
      if (e_oe[cyc]) begin
        chk(wd_rise == e_w0[cyc], "R4 wd_rise", 64'(wd_rise), 64'(e_w0[cyc]));
        chk(wd_fall == e_w1[cyc], "R4 wd_fall", 64'(wd_fall), 64'(e_w1[cyc]));
      end
      chk(rd_valid == e_rv[cyc], cfg_echo ? "R6 R8 rd_valid" : "R5 R8 rd_valid",
          64'(rd_valid), 64'(e_rv[cyc]));
      if (e_rv[cyc]) begin
        chk(rd_tag == e_tag[cyc], "R8 rd_tag", 64'(rd_tag), 64'(e_tag[cyc]));
        chk(rd_data0 == e_r0[cyc], cfg_echo ? "R6 rd_data0" : "R5 rd_data0",
            64'(rd_data0), 64'(e_r0[cyc]));
        chk(rd_data1 == e_r1[cyc], cfg_echo ? "R6 rd_data1" : "R5 rd_data1",
            64'(rd_data1), 64'(e_r1[cyc]));
      end
    end
  end

  // drive one request at a falling edge and record its expectations
  task automatic send(input logic [VW-1:0] v);
    logic          wr;
    logic [AW-1:0] ad;
    logic [DW-1:0] d0, d1;
    logic [TW-1:0] tg;
    int a, lat;
    {wr, ad, d0, d1, tg} = v[VW-1:1];
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = ad;
    req_wdata0 = d0;
    req_wdata1 = d1;
    req_tag    = tg;
    a   = cyc + 1;
    lat = cfg_echo ? 5 : 4;
    e_cmd[a]  = 1'b1;
    e_rw[a]   = !wr;
    e_addr[a] = ad;
    if (wr) begin
      e_oe[a+1] = 1'b1;
      e_w0[a+1] = d0;
      e_w1[a+1] = d1;
      shadow[{ad, 1'b0}] = d0;
      shadow[{ad, 1'b1}] = d1;
    end else begin
      e_rv[a+lat]  = 1'b1;
      e_tag[a+lat] = tg;
      e_r0[a+lat]  = shadow[{ad, 1'b0}];
      e_r1[a+lat]  = shadow[{ad, 1'b1}];
    end
  endtask

  task automatic idle_cycle();
    req_valid = 1'b0;
    req_write = ~req_write;   // R3: level must be ignored while idle
    req_addr  = ~req_addr;
  endtask

  task automatic run_table();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      send(VECS[i]);
      if (VECS[i][0]) begin
        @(negedge clk);
        idle_cycle();
      end
    end
    @(negedge clk);
    idle_cycle();
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < MW; i++) begin
      mem[i]    = DW'(16'h5000 ^ (i * 7));
      shadow[i] = DW'(16'h5000 ^ (i * 7));
    end
    for (int i = 0; i < NE; i++) begin
      e_cmd[i] = 1'b0; e_rw[i] = 1'b0; e_addr[i] = '0; e_oe[i] = 1'b0;
      e_w0[i] = '0; e_w1[i] = '0; e_rv[i] = 1'b0; e_tag[i] = '0;
      e_r0[i] = '0; e_r1[i] = '0;
    end

    // R1: reset state, with a request presented during reset
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h55;
    @(negedge clk);
    chk(sram_ld_n == 1'b1, "R1 ld_n in reset", 64'(sram_ld_n), 64'd1);
    chk(wd_oe == 1'b0, "R1 wd_oe in reset", 64'(wd_oe), 64'd0);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", 64'(rd_valid), 64'd0);
    chk(req_ready == 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(wd_oe == 1'b0, "R1 no write data from reset request", 64'(wd_oe), 64'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after reset", 64'(req_ready), 64'd1);
    chk(sram_ld_n == 1'b1, "R3 idle after reset", 64'(sram_ld_n), 64'd1);
    mon_en = 1'b1;

    // table walk with K-timed read data (R2 R3 R4 R5 R8)
    cfg_echo = 1'b0;
    run_table();

    // same table with echo-timed read data (R6)
    cfg_echo = 1'b1;
    run_table();

    // R7: unbroken run of alternating write/read to fresh addresses
    cfg_echo = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      send({i[0] ? 1'b0 : 1'b1, AW'(8'h60 + i / 2), DW'(16'h7000 + i), DW'(16'h8000 + i), TW'(i), 1'b0});
    end
    @(negedge clk);
    idle_cycle();
    repeat (10) @(negedge clk);

    // R1: reset asserted together with a write request mid-run
    mon_en = 1'b0;
    rst = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h70;
    @(negedge clk);
    chk(sram_ld_n == 1'b1, "R1 ld_n on late reset", 64'(sram_ld_n), 64'd1);
    chk(req_ready == 1'b0, "R1 ready on late reset", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(wd_oe == 1'b0, "R1 wd_oe on late reset", 64'(wd_oe), 64'd0);
    chk(rd_valid == 1'b0, "R1 rd_valid on late reset", 64'(rd_valid), 64'd0);
    req_valid = 1'b0;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end
endmodule